// File: doc/BRIEF.md
# Burst Serial Output Formatter

This block serialises oversampled stereo audio for a downstream converter. It takes a left and a right 20-bit two's complement sample in parallel and sends both at the same time on two data lines, most significant bit first. It also generates the bit clock and word clock that go with the data, using the internal system clock and no other timing source.

Time is divided into word slots of a fixed number of system clocks. A slot is 24 clocks when the narrow slot mode is selected and 32 clocks otherwise. The word clock is high for the first half of each slot and low for the second half. The bit clock produces one pulse for each data bit and then stays idle until the slot ends, so the same slot can carry a 20-bit word or an 18-bit word. A new sample pair is captured at the clock edge where the word clock falls. That pair is then sent in the next slot. The mode pins are read at each slot boundary.

Top module: `burst_serial_out`

## Requirements
- R1: While `rst_n` is sampled low, `wck`, `bck`, `dout_l` and `dout_r` are all 0 from the next clock onward.
- R2: A slot (one period of `wck`, from one rise to the next) lasts 24 clocks when `narrow_sel` = 1 and 32 clocks when `narrow_sel` = 0.
- R3: `wck` is high for the first half of each slot and low for the second half: 12 and 12 clocks, or 16 and 16 clocks. `short_sel` does not change this.
- R4: In each slot `bck` pulses exactly 20 times when `short_sel` = 0 and exactly 18 times when `short_sel` = 1. Each pulse is high during the second half of a clock period. The pulses fall in the first clocks of the slot, one pulse per clock, and there are no pulses for the rest of the slot.
- R5: Data changes when `bck` falls and is read when `bck` rises. Pulse k of a slot (k = 0 first) carries bit 19-k of the sample, so the MSB goes first.
- R6: In 18-bit mode the word sent is bits 19 down to 2 of the 20-bit sample. Bits 1 and 0 are dropped.
- R7: `dout_l` and `dout_r` are 0 in every clock where `bck` does not pulse.
- R8: The sample pair present on `samp_l`/`samp_r` at the clock edge where `wck` falls is the pair sent in the following slot. Values present at any other edge have no effect on the output.
- R9: The left and right words are sent together, each on its own line, and each carries its own sample.
- R10: The first slot after reset sends all-zero words on both lines.
- R11: `narrow_sel` and `short_sel` are taken at the edge that starts a slot and hold for the whole slot. A change in the middle of a slot takes effect at the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_sel | input | 1 | 1: 24-clock slot, 0: 32-clock slot |
| short_sel | input | 1 | 1: 18-bit words, 0: 20-bit words |
| samp_l | input | 20 | Left sample, two's complement |
| samp_r | input | 20 | Right sample, two's complement |
| bck | output | 1 | Burst bit clock |
| wck | output | 1 | Word clock, high in first half of slot |
| dout_l | output | 1 | Left serial data, MSB first |
| dout_r | output | 1 | Right serial data, MSB first |

## Verification
The slot position counter drives every other output. If its state is wrong, the fault shows within one slot as a wrong `wck` period or duty, or as a burst of the wrong length or in the wrong place. A fault in the hold register or the shift register shows as a wrong bit in the next transmitted word, at most two slots after the affected capture. Samples change every clock in the bench. A capture taken at any edge other than the `wck` fall therefore almost always produces a miscompare on the next word.

// File: rtl/bso_pkg.sv
// Package: shared types for the burst serial output formatter.
// Assumes: the configuration is sampled once per slot and held for the whole slot.
package bso_pkg;

    // Configuration latched at each slot boundary
    typedef struct packed {
        logic narrow;      // 1: short slot
        logic short_word;  // 1: reduced word length
    } bso_cfg_t;

endpackage

// File: rtl/bso_slot_timer.sv
// Module: bso_slot_timer
// Counts clock positions within a word slot. Produces the registered word
// clock, the burst enable, and the strobes for slot start and sample capture.
// Assumes: SLOT_NARROW and SLOT_WIDE are even, and each word length is at
// most the smaller slot length.
module bso_slot_timer
    import bso_pkg::*;
#(
    parameter int SLOT_NARROW = 24,
    parameter int SLOT_WIDE   = 32,
    parameter int WORD_LONG   = 20,
    parameter int WORD_SHORT  = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic narrow_sel,
    input  logic short_sel,
    output logic wck_q,
    output logic burst_q,
    output logic slot_start,
    output logic capture
);

    localparam int SLOT_MAX = (SLOT_WIDE > SLOT_NARROW) ? SLOT_WIDE : SLOT_NARROW;
    localparam int PW       = $clog2(SLOT_MAX);

    bso_cfg_t        cfg_q;
    logic [PW-1:0]   pos_q;
    logic [PW-1:0]   pos_nxt;
    logic [PW-1:0]   last_pos;
    logic [PW-1:0]   half_pos;
    logic [PW-1:0]   word_len;

    // Decode slot end, slot midpoint and word length from the latched configuration
    always_comb begin
        last_pos   = cfg_q.narrow ? PW'(SLOT_NARROW - 1) : PW'(SLOT_WIDE - 1);
        half_pos   = cfg_q.narrow ? PW'(SLOT_NARROW / 2) : PW'(SLOT_WIDE / 2);
        word_len   = cfg_q.short_word ? PW'(WORD_SHORT) : PW'(WORD_LONG);
        slot_start = (pos_q >= last_pos);
        pos_nxt    = slot_start ? '0 : pos_q + 1'b1;
        capture    = !slot_start && (pos_nxt == half_pos);
    end

    // Advance the position, latch the configuration at slot start, register the clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '1;
            cfg_q   <= '0;
            wck_q   <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            pos_q   <= pos_nxt;
            wck_q   <= (pos_nxt < half_pos);
            burst_q <= (pos_nxt < word_len);
            if (slot_start) begin
                cfg_q <= '{narrow: narrow_sel, short_word: short_sel};
            end
        end
    end

    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (!wck_q && !burst_q)); // R1

    AST_WCK_FALL_MID: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wck_q) && $past(rst_n)) |-> (pos_q == half_pos)); // R3

    AST_BURST_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_q) |-> (wck_q && pos_q == '0)); // R4

endmodule

// File: rtl/bso_lane.sv
// Module: bso_lane
// One channel: a hold register captured at the word clock fall, and a
// shift register loaded at slot start that shifts out MSB first.
// Assumes: shift_en is high exactly for the bits being sent.
module bso_lane #(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] samp,
    input  logic                capture,
    input  logic                slot_start,
    input  logic                shift_en,
    output logic                msb
);

    logic [SAMPLE_W-1:0] hold_q;
    logic [SAMPLE_W-1:0] sh_q;

    // Capture the sample at the midpoint, then load or shift the output word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (capture) begin
                hold_q <= samp;
            end
            if (slot_start) begin
                sh_q <= hold_q;
            end else if (shift_en) begin
                sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    assign msb = sh_q[SAMPLE_W-1];

    AST_LOAD_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> (sh_q == $past(hold_q))); // R8

endmodule

// File: rtl/burst_serial_out.sv
// Module: burst_serial_out (top)
// Burst-mode stereo serial output formatter. The slot timer drives both
// channel lanes, and the bit clock is the burst enable gated with the
// inverted system clock.
// Assumes: clk is the internal system clock, one bit period per cycle.
module burst_serial_out #(
    parameter int SAMPLE_W    = 20,
    parameter int SHORT_W     = 18,
    parameter int SLOT_NARROW = 24,
    parameter int SLOT_WIDE   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                narrow_sel,
    input  logic                short_sel,
    input  logic [SAMPLE_W-1:0] samp_l,
    input  logic [SAMPLE_W-1:0] samp_r,
    output logic                bck,
    output logic                wck,
    output logic                dout_l,
    output logic                dout_r
);

    localparam int NCH = 2;

    logic                          wck_q;
    logic                          burst_q;
    logic                          slot_start;
    logic                          capture;
    logic [NCH-1:0][SAMPLE_W-1:0]  samp_a;
    logic [NCH-1:0]                msb_a;

    bso_slot_timer #(
        .SLOT_NARROW (SLOT_NARROW),
        .SLOT_WIDE   (SLOT_WIDE),
        .WORD_LONG   (SAMPLE_W),
        .WORD_SHORT  (SHORT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow_sel (narrow_sel),
        .short_sel  (short_sel),
        .wck_q      (wck_q),
        .burst_q    (burst_q),
        .slot_start (slot_start),
        .capture    (capture)
    );

    // Channel 0 is left, channel 1 is right
    assign samp_a = {samp_r, samp_l};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        bso_lane #(
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .samp       (samp_a[ch]),
            .capture    (capture),
            .slot_start (slot_start),
            .shift_en   (burst_q),
            .msb        (msb_a[ch])
        );
    end

    // Gate the output pins: pulses and data appear only during the burst
    always_comb begin
        bck    = burst_q & ~clk;
        wck    = wck_q;
        dout_l = msb_a[0] & burst_q;
        dout_r = msb_a[1] & burst_q;
    end

    AST_DOUT_RST_LOW: assert property (@(posedge clk) !rst_n |=> (!dout_l && !dout_r)); // R1

endmodule

// File: tb/burst_serial_out_tb.sv
`timescale 1ns/1ps
module burst_serial_out_tb;

    localparam int TOTAL = 70000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_sel = 1'b1;
    logic        short_sel = 1'b0;
    logic [19:0] samp_l = '0;
    logic [19:0] samp_r = '0;
    logic        bck, wck, dout_l, dout_r;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Monitor state
    bit          in_slot = 0;
    bit          first_slot = 0;
    bit          prev_wck = 0;
    bit          cfg_n, cfg_s;
    int          pos, hi_cnt, pulses, bck_bad, bad_idle;
    logic [19:0] exp_l, exp_r, nxt_l, nxt_r, got_l, got_r;

    burst_serial_out u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow_sel (narrow_sel),
        .short_sel  (short_sel),
        .samp_l     (samp_l),
        .samp_r     (samp_r),
        .bck        (bck),
        .wck        (wck),
        .dout_l     (dout_l),
        .dout_r     (dout_r)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [19:0] word_of(input logic [19:0] v, input bit s);
        return s ? {2'b00, v[19:2]} : v;
    endfunction

    function automatic logic [19:0] pick();
        case ($urandom % 8)
            0: return 20'hFFFFF;
            1: return 20'h80000;
            2: return 20'h7FFFF;
            3: return 20'h00001;
            default: return 20'($urandom);
        endcase
    endfunction

    task automatic finish_slot();
        int len_e = cfg_n ? 24 : 32;
        int w     = cfg_s ? 18 : 20;
        chk(pos == len_e, "R2 R11 slot length", pos, len_e);
        chk(hi_cnt == len_e / 2, "R3 word clock high time", hi_cnt, len_e / 2);
        chk(pulses == w, "R4 bit clock pulse count", pulses, w);
        chk(bck_bad == 0, "R4 burst placement", bck_bad, 0);
        chk(bad_idle == 0, "R7 idle data low", bad_idle, 0);
        chk(got_l == word_of(exp_l, cfg_s), cfg_s ? "R6 R8 left short word" : "R5 R8 left word",
            got_l, word_of(exp_l, cfg_s));
        chk(got_r == word_of(exp_r, cfg_s), "R9 right word", got_r, word_of(exp_r, cfg_s));
        if (first_slot) begin
            chk(got_l == '0 && got_r == '0, "R10 zero words after reset", {got_l[15:0], got_r[15:0]}, 0);
        end
    endtask

    task automatic observe(input bit in_rst);
        if (in_rst) begin
            chk(!wck && !bck && !dout_l && !dout_r, "R1 outputs quiet in reset",
                {wck, bck, dout_l, dout_r}, 0);
            in_slot  = 0;
            prev_wck = 0;
            nxt_l    = '0;
            nxt_r    = '0;
            first_slot = 1;
            return;
        end
        if (wck && !prev_wck) begin
            if (in_slot) begin
                finish_slot();
                first_slot = 0;
            end
            in_slot  = 1;
            cfg_n    = narrow_sel;
            cfg_s    = short_sel;
            exp_l    = nxt_l;
            exp_r    = nxt_r;
            pos      = 0;
            hi_cnt   = 0;
            pulses   = 0;
            bck_bad  = 0;
            bad_idle = 0;
            got_l    = '0;
            got_r    = '0;
        end
        if (in_slot) begin
            if (wck) hi_cnt++;
            if (bck != (pos < (cfg_s ? 18 : 20))) bck_bad++;
            if (bck) begin
                got_l = {got_l[18:0], dout_l};
                got_r = {got_r[18:0], dout_r};
                pulses++;
            end else if (dout_l || dout_r) begin
                bad_idle++;
            end
            pos++;
        end
        if (!wck && prev_wck) begin
            nxt_l = samp_l;
            nxt_r = samp_r;
        end
        prev_wck = wck;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int cyc = 0; cyc < TOTAL; cyc++) begin
            @(negedge clk);
            observe(!rst_n);
            rst_n = !((cyc < 4) || (cyc >= 30000 && cyc < 30005));
            samp_l = pick();
            samp_r = pick();
            if ($urandom % 400 == 0) narrow_sel = ~narrow_sel;
            if ($urandom % 400 == 0) short_sel = ~short_sel;
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule